// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation converter. A start strobe begins a conversion. The sequencer then resolves the result one bit at a time, beginning with the most significant bit. At each step it presents a trial code to an external comparison path, which is a DAC followed by a comparator. One bit returns from that path, and it reports whether the sampled input is at or above the trial level. The sequencer keeps the trial bit or clears it based on that answer, then moves to the next lower bit.

The end-of-conversion flag (`eoc_o`) is low while a conversion is running. It rises on the same clock edge that loads the finished code into the registered result. A start strobe that arrives during a conversion discards the partial code and begins again from the most significant bit. After each completion there is a short recovery window in which start strobes have no effect. As a result, starts spaced a fixed number of clocks apart always succeed.

The code width, the number of clocks per bit step and the recovery window are parameters. The defaults are 8 bits, 5 clocks per step and 4 clocks of recovery.

Top module: `sar_seq`

## Requirements
- R1: After reset, `eoc_o` is 1 and `result_o` is 0. No recovery window is active, so a start sampled on the first edge after reset is accepted.
- R2: When the block is idle, a start sampled on a rising edge drives `eoc_o` low from that edge. `eoc_o` then stays low for exactly 40 clock periods (8 bits times 5 clocks) before it rises.
- R3: The code is resolved one bit per 5-clock step, MSB first. On the cycle after a start is accepted, `trial_o` is 0x80. The comparator bit `cmp_ge_i` is sampled on the last clock of each step, and 1 means the input is at or above `trial_o`. The trial bit is kept when that bit is 1. Each later `trial_o` is the bits resolved so far plus the next lower bit set. With an ideal comparator, the result equals the input code.
- R4: `result_o` is loaded on the same edge where `eoc_o` rises. It does not change on any other edge.
- R5: A start sampled while `eoc_o` is low clears the partial code and restarts from the MSB. `eoc_o` stays low and then rises exactly 40 clocks after the restarting edge, with the restarted conversion's result.
- R6: An aborted conversion never changes `result_o`.
- R7: Starts sampled on the 1st, 2nd or 3rd rising edge after `eoc_o` rises are ignored. This covers `eoc_o`, `result_o` and any later result. A start sampled on the 4th edge after the rise is accepted.
- R8: Starts issued every 44 clocks are all accepted. Each produces the correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on each rising edge |
| cmp_ge_i | input | 1 | Comparator answer: 1 when the input is at or above `trial_o` |
| trial_o | output | WIDTH | Trial code driven to the DAC |
| eoc_o | output | 1 | End of conversion: low while converting |
| result_o | output | WIDTH | Registered result of the last completed conversion |

## Verification
The checker's properties assume that `start_i` is synchronous to `clk`. They also assume that `cmp_ge_i` is a settled function of the current `trial_o` by the time it is sampled. Under these assumptions, the duration of a conversion and the recovery window follow from the port history alone. The bench models the analog path as a combinational compare of a target code against `trial_o`. It changes the target and drives `start_i` only on falling clock edges, so both inputs are stable at every sampling edge. Whenever a restart is issued, the target is switched at the same moment, so the abandoned partial code can never match the new result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   localparam int unsigned SAR_WIDTH_DEF   = 8;
   localparam int unsigned SAR_STEP_DEF    = 5;
   localparam int unsigned SAR_HOLDOFF_DEF = 4;
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
   parameter int unsigned WIDTH     = sar_seq_pkg::SAR_WIDTH_DEF,
   parameter int unsigned STEP_CLKS = sar_seq_pkg::SAR_STEP_DEF,
   localparam int unsigned IDXW     = $clog2(WIDTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            busy,
   input  logic            launch,
   output logic [IDXW-1:0] bit_idx,
   output logic            step_end,
   output logic            last_step
);
   // Position within a bit step: a counter, or nothing when a step is one clock.
   generate
      if (STEP_CLKS == 1) begin : g_single
         assign step_end = busy;
      end else begin : g_multi
         localparam int unsigned SUBW = $clog2(STEP_CLKS);
         localparam logic [SUBW-1:0] SUB_LAST = SUBW'(STEP_CLKS - 1);
         logic [SUBW-1:0] sub_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sub_q <= '0;
            end else if (launch) begin
               sub_q <= '0;
            end else if (busy) begin
               sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
            end
         end
         assign step_end = busy && (sub_q == SUB_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= IDXW'(WIDTH - 1);
      end else if (launch) begin
         bit_idx <= IDXW'(WIDTH - 1);
      end else if (step_end && bit_idx != '0) begin
         bit_idx <= bit_idx - 1'b1;
      end
   end

   assign last_step = step_end && (bit_idx == '0);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
   parameter int unsigned WIDTH = sar_seq_pkg::SAR_WIDTH_DEF,
   localparam int unsigned IDXW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             busy,
   input  logic             step_end,
   input  logic             cmp_ge,
   input  logic [IDXW-1:0]  bit_idx,
   output logic [WIDTH-1:0] code_next,
   output logic [WIDTH-1:0] trial
);
   logic [WIDTH-1:0] code_q;

   // One slice per code bit: decided on its step's last clock, cleared on launch.
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic sel;
         assign sel          = (bit_idx == IDXW'(i));
         assign code_next[i] = (step_end && sel) ? cmp_ge : code_q[i];
         assign trial[i]     = code_q[i] | (busy & sel);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_q[i] <= 1'b0;
            end else if (launch) begin
               code_q[i] <= 1'b0;
            end else begin
               code_q[i] <= code_next[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sar_holdoff.sv
module sar_holdoff #(
   parameter int unsigned HOLDOFF = sar_seq_pkg::SAR_HOLDOFF_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   output logic hold_active
);
   // Starts are blocked on the first HOLDOFF-1 edges after completion.
   generate
      if (HOLDOFF <= 1) begin : g_none
         assign hold_active = 1'b0;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(HOLDOFF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (done) begin
               cnt_q <= CW'(HOLDOFF - 1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign hold_active = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
   parameter int unsigned WIDTH     = sar_seq_pkg::SAR_WIDTH_DEF,
   parameter int unsigned STEP_CLKS = sar_seq_pkg::SAR_STEP_DEF,
   parameter int unsigned HOLDOFF   = sar_seq_pkg::SAR_HOLDOFF_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_ge_i,
   output logic [WIDTH-1:0] trial_o,
   output logic             eoc_o,
   output logic [WIDTH-1:0] result_o
);
   localparam int unsigned IDXW = $clog2(WIDTH);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_seq: WIDTH must be at least 2");
      end
      if (STEP_CLKS < 1) begin : g_bad_step
         $error("sar_seq: STEP_CLKS must be at least 1");
      end
      if (HOLDOFF < 1) begin : g_bad_hold
         $error("sar_seq: HOLDOFF must be at least 1");
      end
   endgenerate

   logic            busy_q;
   logic            hold_active;
   logic            launch;
   logic            step_end;
   logic            last_step;
   logic            done;
   logic [IDXW-1:0] bit_idx;
   logic [WIDTH-1:0] code_next;

   // A start always wins while busy (restart); when idle it waits out the holdoff.
   assign launch = start_i && (busy_q || !hold_active);
   assign done   = last_step && !launch;

   sar_step_timer #(.WIDTH(WIDTH), .STEP_CLKS(STEP_CLKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_q),
      .launch    (launch),
      .bit_idx   (bit_idx),
      .step_end  (step_end),
      .last_step (last_step)
   );

   sar_approx_reg #(.WIDTH(WIDTH)) u_approx (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .busy      (busy_q),
      .step_end  (step_end),
      .cmp_ge    (cmp_ge_i),
      .bit_idx   (bit_idx),
      .code_next (code_next),
      .trial     (trial_o)
   );

   sar_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .hold_active (hold_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         result_o <= '0;
      end else begin
         if (launch) begin
            busy_q <= 1'b1;
         end else if (done) begin
            busy_q <= 1'b0;
         end
         if (done) begin
            result_o <= code_next;
         end
      end
   end

   assign eoc_o = !busy_q;
endmodule

// File: rtl/sar_seq_check.sv
module sar_seq_check #(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned STEP_CLKS = 5,
   parameter int unsigned HOLDOFF   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [WIDTH-1:0] trial_o,
   input logic             eoc_o,
   input logic [WIDTH-1:0] result_o
);
   localparam int CONV_CLKS = int'(WIDTH * STEP_CLKS);
   localparam int HOLD_EDGES = int'(HOLDOFF) - 1;

   int low_cnt;
   int since_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt    <= 0;
         since_rise <= int'(HOLDOFF);
      end else begin
         if (!eoc_o) begin
            low_cnt <= start_i ? 0 : low_cnt + 1;
         end else begin
            low_cnt <= 0;
         end
         if (!eoc_o) begin
            since_rise <= 0;
         end else if (since_rise < int'(HOLDOFF)) begin
            since_rise <= since_rise + 1;
         end
      end
   end

   // R2 / R5: busy never lasts longer than one conversion from the last start
   a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_o |-> low_cnt < CONV_CLKS);

   // R3: the first trial after a start is the MSB alone
   a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc_o) |-> trial_o == {1'b1, {(WIDTH-1){1'b0}}});

   // R4 / R6: the result moves only together with the rise of eoc
   a_r4_result_on_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(eoc_o) |-> $stable(result_o));

   // R5: a start while busy keeps the block busy
   a_r5_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!eoc_o && start_i) |=> !eoc_o);

   // R7: starts inside the recovery window are ignored
   a_r7_holdoff_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_o && since_rise < HOLD_EDGES && start_i) |=> eoc_o);

   // R7 / R8: a start after the window is accepted
   a_r7_accept_after: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_o && since_rise >= HOLD_EDGES && start_i) |=> !eoc_o);
endmodule

bind sar_seq sar_seq_check #(
   .WIDTH(WIDTH), .STEP_CLKS(STEP_CLKS), .HOLDOFF(HOLDOFF)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .trial_o  (trial_o),
   .eoc_o    (eoc_o),
   .result_o (result_o)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       cmp_ge_i;
   logic [7:0] trial_o;
   logic       eoc_o;
   logic [7:0] result_o;
   logic [7:0] target = 8'h00;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   // Ideal analog path: input level is 'target'
   assign cmp_ge_i = (target >= trial_o);

   sar_seq uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .cmp_ge_i (cmp_ge_i),
      .trial_o  (trial_o),
      .eoc_o    (eoc_o),
      .result_o (result_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Start sampled on the next rising edge; returns on the falling edge after it
   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Counts low cycles of eoc; checks result holds 'held' meanwhile (R4, R6)
   task automatic wait_eoc(input string req, input logic [7:0] held, output int n);
      n = 0;
      while (!eoc_o && n < 100) begin
         if (result_o != held) chk({req, " result held while busy"}, result_o, held);
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R1 eoc after reset", eoc_o, 1);
      chk("R1 result after reset", result_o, 0);
   endtask

   // Caller is on a falling edge where a start is allowed; ends 3 edges after eoc rises
   task automatic t_convert(input logic [7:0] tgt, input string req);
      logic [7:0] old;
      int n;
      old = result_o;
      target = tgt;
      pulse_start();
      chk({req, " eoc low after start"}, eoc_o, 0);
      wait_eoc(req, old, n);
      chk({req, " R2 busy length"}, n, 40);
      chk({req, " R3 result"}, result_o, tgt);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_trial();
      int n;
      logic [7:0] old;
      old = result_o;
      target = 8'hC3;
      pulse_start();
      chk("R3 first trial MSB", trial_o, 8'h80);
      repeat (5) @(negedge clk);
      chk("R3 second trial", trial_o, 8'hC0);
      repeat (5) @(negedge clk);
      chk("R3 third trial", trial_o, 8'hE0);
      repeat (5) @(negedge clk);
      chk("R3 fourth trial", trial_o, 8'hD0);
      chk("R4 result held mid-conversion", result_o, old);
      wait_eoc("R4", old, n);
      chk("R2 busy length trial run", n + 15, 40);
      chk("R4 result on eoc rise", result_o, 8'hC3);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_restart();
      int n;
      logic [7:0] old;
      old = result_o;
      target = 8'h3C;
      pulse_start();
      repeat (16) @(negedge clk);
      chk("R5 busy before restart", eoc_o, 0);
      target = 8'hD2;
      pulse_start();
      chk("R5 still busy after restart", eoc_o, 0);
      chk("R5 trial cleared to MSB", trial_o, 8'h80);
      wait_eoc("R6", old, n);
      chk("R5 length after restart", n, 40);
      chk("R5 restarted result", result_o, 8'hD2);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_holdoff();
      int n;
      target = 8'h55;
      pulse_start();
      wait_eoc("R7", result_o, n);
      chk("R7 setup result", result_o, 8'h55);
      target = 8'h99;
      start_i = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk($sformatf("R7 start ignored edge %0d", k), eoc_o, 1);
      end
      chk("R7 result untouched", result_o, 8'h55);
      @(negedge clk);
      start_i = 1'b0;
      chk("R7 start accepted 4th edge", eoc_o, 0);
      wait_eoc("R7", 8'h55, n);
      chk("R7 accepted result", result_o, 8'h99);
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_convert(8'hA5, "R1 first start accepted");
      t_trial();
      t_restart();
      t_holdoff();
      // R8: back-to-back starts at a 44-clock pitch
      t_convert(8'h00, "R8");
      t_convert(8'hFF, "R8");
      t_convert(8'h80, "R8");
      t_convert(8'h7F, "R8");
      t_convert(8'h01, "R8");
      summary();
      $finish;
   end
endmodule